// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Mode

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, weekday, day of month, month and a two-digit year, all in packed BCD, and steps them once per second. The one-second tick comes from an internal prescaler that divides the block clock by `TICKS_PER_SEC`. The year covers 2000 to 2099, so leap years follow from divisibility by four alone.

A host loads any field through a plain write port (`wr_en_i`, `wr_addr_i`, `wr_data_i`) and sees every field at once on parallel outputs. The hour register is encoded in one of two ways. In 24-hour mode it holds BCD 00 to 23. In 12-hour mode, bits 4:0 hold BCD 1 to 12 and bit 5 marks PM. A control word selects the mode and also manages a stop flag. That flag is raised at power-up or when `osc_fail_i` reports lost timekeeping. It stays raised until the host explicitly clears it, normally after loading a valid time.

The port has no back-pressure: a write takes effect at the clock edge on which `wr_en_i` is high. The outputs are registered state and are always valid.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the block holds the following state. Stop flag is 1 and 12-hour mode is selected. Hour is 0x12 (midnight), minute and second are 0x00, weekday is 0, day is 0x01, month is 0x01 and year is 0x00.
- R2: Seconds advance by one BCD step once every `TICKS_PER_SEC` clock cycles. Second 0x59 wraps to 0x00 and carries into the minute.
- R3: Minute 0x59 wraps to 0x00 on a carry and carries into the hour. Other minute values step by one BCD count.
- R4: In 24-hour mode (control bit 0 = 1) the hour counts 0x00 to 0x23. Hour 0x23 wraps to 0x00 and carries into the date.
- R5: In 12-hour mode (control bit 0 = 0), bit 5 of the hour is PM and bits 4:0 hold BCD 1 to 12. The steps 0x11→0x32 and 0x32→0x21 do not carry into the date. Neither does 0x12→0x01. Only 0x31→0x12 carries into the date.
- R6: The day of month wraps to 0x01 and carries into the month after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in all other months except 0x02.
- R7: February (month 0x02) ends at 0x29 when the binary value of the BCD year is divisible by 4, including year 0x00. Otherwise it ends at 0x28.
- R8: Month 0x12 wraps to 0x01 and increments the year. Year 0x99 wraps to 0x00.
- R9: The weekday (0 to 6) steps by one on every date carry and wraps from 6 to 0. The day changes only at the same edge as an hour change.
- R10: Write addresses are 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month, 6 year and 7 control. A write stores the low bits of `wr_data_i` into the field. A write to addresses 0 to 6 restarts the prescaler, so the next second step comes exactly `TICKS_PER_SEC` cycles after the write edge.
- R11: A write to address 7 sets the mode from bit 0 and leaves the stored hour code unchanged. If bit 1 is 0 the write clears the stop flag; if bit 1 is 1 the flag is left as it was. Host writes never set the flag.
- R12: `osc_fail_i` high at an edge sets the stop flag. This takes priority over a clear issued at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_fail_i | input | 1 | Timekeeping-lost indication; sets the stop flag |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hour code (24-hour BCD, or 12-hour with PM in bit 5) |
| wday_o | output | 3 | Weekday 0 to 6 |
| mday_o | output | 6 | Day of month, BCD |
| mon_o | output | 5 | Month, BCD 01 to 12 |
| year_o | output | 8 | Year, BCD 00 to 99 |
| mode24_o | output | 1 | 1 = 24-hour encoding selected |
| osc_stop_o | output | 1 | Stop flag |

## Verification
The bench loads times just before each kind of rollover and checks the state one second later.

- A plain second step is compared against a minute carry and a full year-end cascade, which shows that carries propagate only where they should.
- In 12-hour mode the four special hour transitions are each tried, and they separate the PM toggle from the date carry.
- Month ends are tried in a 30-day month, a 31-day month, February in a common year, February in a leap year, and year 00. These show that month length and leap selection come from the right fields.
- Writes placed mid-second, and control writes with each value of the keep bit, show the prescaler restart and the rules of the stop flag.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_CTRL = 3'd7
  } field_e;

  localparam int CTRL_MODE24_BIT = 0;
  localparam int CTRL_KEEP_BIT   = 1;

  // one decimal step of a two-digit packed BCD value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    bcd2bin = ({3'd0, v[7:4]} * 7'd10) + {3'd0, v[3:0]};
  endfunction

  function automatic logic is_leap(input logic [7:0] year);
    logic [6:0] b;
    b = bcd2bin(year);
    is_leap = (b[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] year);
    case (mon)
      5'h02:                      last_day = is_leap(year) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST) && !restart_i;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       mode24_i,
  input  logic       wr_en_i,
  input  field_e     wr_field_i,
  input  logic [7:0] wr_data_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic       day_carry_o
);
  localparam int NSEXA = 2;

  logic [6:0] sx_q   [NSEXA];
  logic       sx_cin [NSEXA+1];

  assign sx_cin[0] = tick_i;

  // seconds and minutes are identical base-60 BCD stages
  for (genvar g = 0; g < NSEXA; g++) begin : g_sexa
    localparam field_e MY_FLD = (g == 0) ? FLD_SEC : FLD_MIN;
    logic       wrap;
    logic [7:0] inc;
    assign wrap          = (sx_q[g] >= 7'h59);
    assign inc           = bcd_inc({1'b0, sx_q[g]});
    assign sx_cin[g+1]   = sx_cin[g] && wrap;

    always_ff @(posedge clk) begin
      if (!rst_n)                              sx_q[g] <= '0;
      else if (wr_en_i && wr_field_i == MY_FLD) sx_q[g] <= wr_data_i[6:0];
      else if (sx_cin[g])                      sx_q[g] <= wrap ? 7'h00 : inc[6:0];
    end
  end

  logic [5:0] hour_q, hour_nxt;
  logic       hour_wrap;
  logic [7:0] inc24, inc12;

  assign inc24 = bcd_inc({2'b00, hour_q});
  assign inc12 = bcd_inc({3'b000, hour_q[4:0]});

  always_comb begin
    hour_nxt  = hour_q;
    hour_wrap = 1'b0;
    if (mode24_i) begin
      if (hour_q >= 6'h23) begin
        hour_nxt  = 6'h00;
        hour_wrap = 1'b1;
      end else begin
        hour_nxt = inc24[5:0];
      end
    end else begin
      case (hour_q[4:0])
        5'h11: begin
          hour_nxt  = {~hour_q[5], 5'h12};
          hour_wrap = hour_q[5];
        end
        5'h12:   hour_nxt = {hour_q[5], 5'h01};
        default: hour_nxt = {hour_q[5], inc12[4:0]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                 hour_q <= 6'h12;
    else if (wr_en_i && wr_field_i == FLD_HOUR) hour_q <= wr_data_i[5:0];
    else if (sx_cin[NSEXA])                     hour_q <= hour_nxt;
  end

  assign sec_o       = sx_q[0];
  assign min_o       = sx_q[1];
  assign hour_o      = hour_q;
  assign day_carry_o = sx_cin[NSEXA] && hour_wrap;
endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry_i,
  input  logic       wr_en_i,
  input  field_e     wr_field_i,
  input  logic [7:0] wr_data_i,
  output logic [2:0] wday_o,
  output logic [5:0] mday_o,
  output logic [4:0] mon_o,
  output logic [7:0] year_o
);
  localparam logic [2:0] WDAY_LAST = 3'd6;

  logic [2:0] wday_q;
  logic [5:0] mday_q;
  logic [4:0] mon_q;
  logic [7:0] year_q;

  logic       mday_wrap, mon_wrap;
  logic [7:0] mday_inc, mon_inc, year_inc;

  assign mday_wrap = (mday_q >= last_day(mon_q, year_q));
  assign mon_wrap  = (mon_q >= 5'h12);
  assign mday_inc  = bcd_inc({2'b00, mday_q});
  assign mon_inc   = bcd_inc({3'b000, mon_q});
  assign year_inc  = bcd_inc(year_q);

  always_ff @(posedge clk) begin
    if (!rst_n)                                 wday_q <= '0;
    else if (wr_en_i && wr_field_i == FLD_WDAY) wday_q <= wr_data_i[2:0];
    else if (day_carry_i)                       wday_q <= (wday_q >= WDAY_LAST) ? 3'd0 : wday_q + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                 mday_q <= 6'h01;
    else if (wr_en_i && wr_field_i == FLD_MDAY) mday_q <= wr_data_i[5:0];
    else if (day_carry_i)                       mday_q <= mday_wrap ? 6'h01 : mday_inc[5:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                 mon_q <= 5'h01;
    else if (wr_en_i && wr_field_i == FLD_MON)  mon_q <= wr_data_i[4:0];
    else if (day_carry_i && mday_wrap)          mon_q <= mon_wrap ? 5'h01 : mon_inc[4:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                 year_q <= 8'h00;
    else if (wr_en_i && wr_field_i == FLD_YEAR) year_q <= wr_data_i;
    else if (day_carry_i && mday_wrap && mon_wrap)
      year_q <= (year_q >= 8'h99) ? 8'h00 : year_inc;
  end

  assign wday_o = wday_q;
  assign mday_o = mday_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_fail_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic [2:0] wday_o,
  output logic [5:0] mday_o,
  output logic [4:0] mon_o,
  output logic [7:0] year_o,
  output logic       mode24_o,
  output logic       osc_stop_o
);
  field_e wr_field;
  logic   time_wr, ctrl_wr, tick, day_carry;
  logic   mode24_q, stop_q;

  assign wr_field = field_e'(wr_addr_i);
  assign ctrl_wr  = wr_en_i && (wr_field == FLD_CTRL);
  assign time_wr  = wr_en_i && (wr_field != FLD_CTRL);

  rtc_tick_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (time_wr),
    .tick_o    (tick)
  );

  rtc_time_counter u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .mode24_i    (mode24_q),
    .wr_en_i     (wr_en_i),
    .wr_field_i  (wr_field),
    .wr_data_i   (wr_data_i),
    .sec_o       (sec_o),
    .min_o       (min_o),
    .hour_o      (hour_o),
    .day_carry_o (day_carry)
  );

  rtc_date_counter u_date (
    .clk         (clk),
    .rst_n       (rst_n),
    .day_carry_i (day_carry),
    .wr_en_i     (wr_en_i),
    .wr_field_i  (wr_field),
    .wr_data_i   (wr_data_i),
    .wday_o      (wday_o),
    .mday_o      (mday_o),
    .mon_o       (mon_o),
    .year_o      (year_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mode24_q <= 1'b0;
    else if (ctrl_wr) mode24_q <= wr_data_i[CTRL_MODE24_BIT];
  end

  // failure indication outranks a host clear at the same edge
  always_ff @(posedge clk) begin
    if (!rst_n)                                   stop_q <= 1'b1;
    else if (osc_fail_i)                          stop_q <= 1'b1;
    else if (ctrl_wr && !wr_data_i[CTRL_KEEP_BIT]) stop_q <= 1'b0;
  end

  assign mode24_o   = mode24_q;
  assign osc_stop_o = stop_q;
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_fail_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic       keep_bit_i,
  input logic [6:0] sec_o,
  input logic [5:0] hour_o,
  input logic [5:0] mday_o,
  input logic       osc_stop_o
);
  // R11
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_stop_o) |-> $past(wr_en_i && wr_addr_i == 3'd7 && !keep_bit_i && !osc_fail_i));

  // R12
  stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail_i |=> osc_stop_o);

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en_i) && !$stable(sec_o)) |->
      (sec_o == 7'h00 || {1'b0, sec_o} == rtc_cal_pkg::bcd_inc({1'b0, $past(sec_o)})));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i != 3'd0 && wr_addr_i != 3'd7) |=> $stable(sec_o));

  // R9
  date_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en_i) && !$stable(mday_o)) |-> !$stable(hour_o));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_fail_i (osc_fail_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .keep_bit_i (wr_data_i[1]),
  .sec_o      (sec_o),
  .hour_o     (hour_o),
  .mday_o     (mday_o),
  .osc_stop_o (osc_stop_o)
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_fail_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, mday_o;
  logic [2:0] wday_o;
  logic [4:0] mon_o;
  logic [7:0] year_o;
  logic       mode24_o, osc_stop_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  rtc_calendar_core #(.TICKS_PER_SEC(TPS)) u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic one_sec();
    repeat (TPS) @(negedge clk);
  endtask

  // control keeps the stop flag (bit1 = 1); sec written last restarts the second
  task automatic set_all(input logic m24, input logic [7:0] y, mo, d, wd, h, mi, s);
    wr(3'd7, {6'd0, 1'b1, m24});
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd3, wd);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  task automatic t_reset();
    chk("R1 stop", {7'd0, osc_stop_o}, 8'h01);
    chk("R1 mode", {7'd0, mode24_o}, 8'h00);
    chk("R1 hour", {2'd0, hour_o}, 8'h12);
    chk("R1 min",  {1'd0, min_o}, 8'h00);
    chk("R1 sec",  {1'd0, sec_o}, 8'h00);
    chk("R1 wday", {5'd0, wday_o}, 8'h00);
    chk("R1 mday", {2'd0, mday_o}, 8'h01);
    chk("R1 mon",  {3'd0, mon_o}, 8'h01);
    chk("R1 year", year_o, 8'h00);
  endtask

  task automatic t_sec_min();
    set_all(1'b1, 8'h23, 8'h03, 8'h10, 8'h2, 8'h05, 8'h59, 8'h58);
    one_sec();
    chk("R2 sec step", {1'd0, sec_o}, 8'h59);
    chk("R2 no min carry", {1'd0, min_o}, 8'h59);
    one_sec();
    chk("R2 sec wrap", {1'd0, sec_o}, 8'h00);
    chk("R3 min wrap", {1'd0, min_o}, 8'h00);
    chk("R3 hour step", {2'd0, hour_o}, 8'h06);
    set_all(1'b1, 8'h23, 8'h03, 8'h10, 8'h2, 8'h05, 8'h29, 8'h59);
    one_sec();
    chk("R3 min step", {1'd0, min_o}, 8'h30);
  endtask

  task automatic t_24h_year_end();
    set_all(1'b1, 8'h99, 8'h12, 8'h31, 8'h6, 8'h23, 8'h59, 8'h59);
    one_sec();
    chk("R4 hour wrap", {2'd0, hour_o}, 8'h00);
    chk("R6 day wrap", {2'd0, mday_o}, 8'h01);
    chk("R8 month wrap", {3'd0, mon_o}, 8'h01);
    chk("R8 year wrap", year_o, 8'h00);
    chk("R9 wday wrap", {5'd0, wday_o}, 8'h00);
    set_all(1'b1, 8'h45, 8'h12, 8'h31, 8'h1, 8'h23, 8'h59, 8'h59);
    one_sec();
    chk("R8 year step", year_o, 8'h46);
    chk("R9 wday step", {5'd0, wday_o}, 8'h02);
  endtask

  task automatic t_12h();
    set_all(1'b0, 8'h10, 8'h05, 8'h05, 8'h2, 8'h11, 8'h59, 8'h59);
    one_sec();
    chk("R5 11AM->12PM", {2'd0, hour_o}, 8'h32);
    chk("R5 no day carry at noon", {2'd0, mday_o}, 8'h05);
    set_all(1'b0, 8'h10, 8'h05, 8'h05, 8'h2, 8'h32, 8'h59, 8'h59);
    one_sec();
    chk("R5 12PM->1PM", {2'd0, hour_o}, 8'h21);
    set_all(1'b0, 8'h10, 8'h05, 8'h05, 8'h2, 8'h31, 8'h59, 8'h59);
    one_sec();
    chk("R5 11PM->12AM", {2'd0, hour_o}, 8'h12);
    chk("R5 day carry at midnight", {2'd0, mday_o}, 8'h06);
    chk("R9 wday on midnight", {5'd0, wday_o}, 8'h03);
    set_all(1'b0, 8'h10, 8'h05, 8'h05, 8'h2, 8'h12, 8'h59, 8'h59);
    one_sec();
    chk("R5 12AM->1AM", {2'd0, hour_o}, 8'h01);
    chk("R5 no day carry 1AM", {2'd0, mday_o}, 8'h05);
    set_all(1'b0, 8'h10, 8'h05, 8'h05, 8'h2, 8'h09, 8'h59, 8'h59);
    one_sec();
    chk("R5 9AM->10AM", {2'd0, hour_o}, 8'h10);
  endtask

  task automatic month_end(input string tag, input logic [7:0] y, mo, d,
                           input logic [7:0] exp_d, exp_mo);
    set_all(1'b1, y, mo, d, 8'h0, 8'h23, 8'h59, 8'h59);
    one_sec();
    chk({tag, " day"}, {2'd0, mday_o}, exp_d);
    chk({tag, " month"}, {3'd0, mon_o}, exp_mo);
  endtask

  task automatic t_months();
    month_end("R6 Apr30", 8'h23, 8'h04, 8'h30, 8'h01, 8'h05);
    month_end("R6 Nov30", 8'h23, 8'h11, 8'h30, 8'h01, 8'h12);
    month_end("R6 Jan30", 8'h23, 8'h01, 8'h30, 8'h31, 8'h01);
    month_end("R6 Jan31", 8'h23, 8'h01, 8'h31, 8'h01, 8'h02);
    month_end("R6 Sep29", 8'h23, 8'h09, 8'h29, 8'h30, 8'h09);
    month_end("R7 Feb28 common", 8'h23, 8'h02, 8'h28, 8'h01, 8'h03);
    month_end("R7 Feb28 leap24", 8'h24, 8'h02, 8'h28, 8'h29, 8'h02);
    month_end("R7 Feb29 leap24", 8'h24, 8'h02, 8'h29, 8'h01, 8'h03);
    month_end("R7 Feb28 year00", 8'h00, 8'h02, 8'h28, 8'h29, 8'h02);
    month_end("R7 Feb28 leap16", 8'h16, 8'h02, 8'h28, 8'h29, 8'h02);
    month_end("R7 Feb28 common18", 8'h18, 8'h02, 8'h28, 8'h01, 8'h03);
  endtask

  task automatic t_prescaler();
    set_all(1'b1, 8'h30, 8'h06, 8'h15, 8'h1, 8'h08, 8'h20, 8'h10);
    repeat (TPS - 1) @(negedge clk);
    chk("R10 hold before tick", {1'd0, sec_o}, 8'h10);
    @(negedge clk);
    chk("R10 tick after full second", {1'd0, sec_o}, 8'h11);
    repeat (2) @(negedge clk);
    wr(3'd1, 8'h33);
    chk("R10 min written", {1'd0, min_o}, 8'h33);
    repeat (TPS - 1) @(negedge clk);
    chk("R10 restart after mid-second write", {1'd0, sec_o}, 8'h11);
    @(negedge clk);
    chk("R10 tick after restart", {1'd0, sec_o}, 8'h12);
  endtask

  task automatic t_ctrl();
    set_all(1'b1, 8'h30, 8'h06, 8'h15, 8'h1, 8'h15, 8'h00, 8'h00);
    wr(3'd7, 8'h02);
    chk("R11 mode to 12h", {7'd0, mode24_o}, 8'h00);
    chk("R11 hour not re-encoded", {2'd0, hour_o}, 8'h15);
    chk("R11 keep leaves stop set", {7'd0, osc_stop_o}, 8'h01);
    wr(3'd7, 8'h01);
    chk("R11 clear stop", {7'd0, osc_stop_o}, 8'h00);
    chk("R11 mode to 24h", {7'd0, mode24_o}, 8'h01);
    wr(3'd7, 8'h03);
    chk("R11 host cannot set stop", {7'd0, osc_stop_o}, 8'h00);
    wr(3'd0, 8'h20);
    chk("R11 time write leaves stop clear", {7'd0, osc_stop_o}, 8'h00);
  endtask

  task automatic t_fail();
    @(negedge clk);
    osc_fail_i = 1'b1;
    @(negedge clk);
    osc_fail_i = 1'b0;
    chk("R12 fail sets stop", {7'd0, osc_stop_o}, 8'h01);
    @(negedge clk);
    osc_fail_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd7; wr_data_i = 8'h01;
    @(negedge clk);
    osc_fail_i = 1'b0; wr_en_i = 1'b0;
    chk("R12 fail beats clear", {7'd0, osc_stop_o}, 8'h01);
    wr(3'd7, 8'h01);
    chk("R12 clear after fail", {7'd0, osc_stop_o}, 8'h00);
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sec_min();
    t_24h_year_end();
    t_12h();
    t_months();
    t_prescaler();
    t_ctrl();
    t_fail();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule